// File: doc/BRIEF.md
# Packet-Locked Receive AGC Controller

This block closes the digital part of a receive gain loop that has two stages: a coarse RF attenuator with two settings, and a linear IF amplifier driven by a 7-bit DAC code. After a packet starts, the block tracks the peak magnitude of the signed 6-bit I and Q converter samples over fixed windows. It moves the IF code until that peak falls inside a programmable band. It then freezes the whole gain setting until the packet ends.

A separate comparator flag from the IF level sensor requests the RF pad. When the flag is seen, the pad is switched in and the IF code is raised by the same amount, a step of `PAD_COMP` codes (30 dB at the default scale of 1 dB per code). The block also reports a compensated signal-strength value, which is the total gain removed from the chain. This value does not jump when the pad engages. Packet start and packet end arrive as one-cycle pulses from the packet detector.

Top module: `rx_agc_ctrl`

## Requirements
- R1: After reset, if_code_o is 127, rf_pad_o is 0, lock_o is 0 and rssi_o is 0.
- R2: The level measure is the largest magnitude of any I or Q sample in a 16-valid-sample window, read as two's complement, so that -32 counts as magnitude 32.
- R3: While a packet is active and unlocked, a window peak strictly above thr_hi_i lowers if_code_o by 2, saturating at 0.
- R4: While a packet is active and unlocked, a window peak strictly below thr_lo_i raises if_code_o by 1, saturating at 127.
- R5: A window peak inside the band, with both edges included, leaves if_code_o unchanged. Two consecutive in-band windows set lock_o. An out-of-band window restarts the count.
- R6: While lock_o is 1, if_code_o and rf_pad_o hold whatever the samples or if_sat_i do.
- R7: if_sat_i high while a packet is active, unlocked and unpadded sets rf_pad_o and raises if_code_o by 30, saturating at 127. This step takes priority over a window result in the same cycle.
- R8: rssi_o equals (127 - if_code_o) + 30 when rf_pad_o is 1, and (127 - if_code_o) when it is 0. It is therefore unchanged across a pad step that does not saturate.
- R9: pkt_end_i clears lock_o and rf_pad_o, sets if_code_o to 127 and stops the loop. Samples and if_sat_i have no effect until the next pkt_start_i.
- R10: pkt_start_i discards any partial window and the in-band count, and clears lock_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_start_i | input | 1 | Packet start pulse |
| pkt_end_i | input | 1 | Packet end pulse |
| smp_vld_i | input | 1 | I/Q sample valid |
| smp_i_i | input | 6 | Signed I sample |
| smp_q_i | input | 6 | Signed Q sample |
| thr_hi_i | input | 6 | Upper band threshold (magnitude) |
| thr_lo_i | input | 6 | Lower band threshold (magnitude) |
| if_sat_i | input | 1 | IF level sensor comparator flag |
| if_code_o | output | 7 | IF gain DAC code |
| rf_pad_o | output | 1 | RF attenuation pad enable |
| lock_o | output | 1 | Gain locked for the current packet |
| rssi_o | output | 8 | Compensated signal strength (gain removed, in codes) |

## Verification
The bench builds the block with its defaults: a 16-sample window, a two-window lock rule, steps of -2/+1 and a 30-code pad step. With the 6-bit sample width, the most negative sample (-32) becomes a legal stimulus, and it is the case where the magnitude is one larger than any positive value. The 7-bit code range is short enough that the bench can drive the code all the way down to 0 and then apply a pad step that does not saturate. It also applies a pad step at 127 that saturates, and it checks that rssi_o stays put across the unsaturated step.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_IN   = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;
endpackage

// File: rtl/agc_peak_meter.sv
module agc_peak_meter #(
  parameter int SMP_W = 6,
  parameter int WIN   = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    vld_i,
  input  logic signed [SMP_W-1:0] i_i,
  input  logic signed [SMP_W-1:0] q_i,
  output logic                    win_vld_o,
  output logic [SMP_W-1:0]        win_peak_o
);
  localparam int CNT_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN - 1);

  logic signed [SMP_W-1:0] smp [2];
  logic [SMP_W-1:0]        mag [2];
  logic [SMP_W-1:0]        peak_q, smp_pk, nxt_pk;
  logic [CNT_W-1:0]        cnt_q;

  assign smp[0] = i_i;
  assign smp[1] = q_i;

  // unsigned magnitude; most negative input maps to 2**(SMP_W-1)
  for (genvar ch = 0; ch < 2; ch++) begin : g_mag
    assign mag[ch] = smp[ch][SMP_W-1] ? SMP_W'(-smp[ch]) : SMP_W'(smp[ch]);
  end

  assign smp_pk = (mag[0] > mag[1]) ? mag[0] : mag[1];
  assign nxt_pk = (smp_pk > peak_q) ? smp_pk : peak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      peak_q     <= '0;
      win_vld_o  <= 1'b0;
      win_peak_o <= '0;
    end else begin
      win_vld_o <= 1'b0;
      if (clr_i) begin
        cnt_q  <= '0;
        peak_q <= '0;
      end else if (vld_i) begin
        if (cnt_q == CNT_LAST) begin
          cnt_q      <= '0;
          peak_q     <= '0;
          win_vld_o  <= 1'b1;
          win_peak_o <= nxt_pk;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          peak_q <= nxt_pk;
        end
      end
    end
  end
endmodule

// File: rtl/agc_gain_loop.sv
module agc_gain_loop
  import agc_pkg::*;
#(
  parameter int SMP_W     = 6,
  parameter int CODE_W    = 7,
  parameter int STEP_DN   = 2,
  parameter int STEP_UP   = 1,
  parameter int PAD_COMP  = 30,
  parameter int LOCK_WINS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_start_i,
  input  logic              pkt_end_i,
  input  logic              win_vld_i,
  input  logic [SMP_W-1:0]  win_peak_i,
  input  logic [SMP_W-1:0]  thr_hi_i,
  input  logic [SMP_W-1:0]  thr_lo_i,
  input  logic              pad_req_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pad_o,
  output logic              lock_o,
  output logic              restart_o
);
  localparam int EW    = CODE_W + 1;
  localparam int LCW   = $clog2(LOCK_WINS + 1);
  localparam logic [EW-1:0]  MAX_E    = EW'((1 << CODE_W) - 1);
  localparam logic [EW-1:0]  UP_E     = EW'(STEP_UP);
  localparam logic [EW-1:0]  DN_E     = EW'(STEP_DN);
  localparam logic [EW-1:0]  PAD_E    = EW'(PAD_COMP);
  localparam logic [LCW-1:0] LOCK_CNT = LCW'(LOCK_WINS - 1);

  logic            active_q;
  logic [LCW-1:0]  inband_q;
  logic [EW-1:0]   code_e, up_sum, pad_sum;
  logic [CODE_W-1:0] code_up, code_dn, code_pad;
  logic            loop_en, pad_step;
  lvl_e            lvl;

  assign code_e   = {1'b0, code_o};
  assign up_sum   = code_e + UP_E;
  assign pad_sum  = code_e + PAD_E;
  assign code_up  = (up_sum  > MAX_E) ? MAX_E[CODE_W-1:0] : up_sum[CODE_W-1:0];
  assign code_pad = (pad_sum > MAX_E) ? MAX_E[CODE_W-1:0] : pad_sum[CODE_W-1:0];
  assign code_dn  = (code_e < DN_E) ? '0 : code_o - DN_E[CODE_W-1:0];

  always_comb begin
    if (win_peak_i > thr_hi_i)      lvl = LVL_HIGH;
    else if (win_peak_i < thr_lo_i) lvl = LVL_LOW;
    else                            lvl = LVL_IN;
  end

  assign loop_en   = active_q && !lock_o && !pkt_start_i && !pkt_end_i;
  assign pad_step  = loop_en && pad_req_i && !pad_o;
  assign restart_o = pkt_start_i || pkt_end_i || pad_step || !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      inband_q <= '0;
      code_o   <= MAX_E[CODE_W-1:0];
      pad_o    <= 1'b0;
      lock_o   <= 1'b0;
    end else if (pkt_end_i) begin
      active_q <= 1'b0;
      inband_q <= '0;
      code_o   <= MAX_E[CODE_W-1:0];
      pad_o    <= 1'b0;
      lock_o   <= 1'b0;
    end else if (pkt_start_i) begin
      active_q <= 1'b1;
      inband_q <= '0;
      lock_o   <= 1'b0;
    end else if (pad_step) begin
      pad_o    <= 1'b1;
      code_o   <= code_pad;
      inband_q <= '0;
    end else if (loop_en && win_vld_i) begin
      unique case (lvl)
        LVL_HIGH: begin
          code_o   <= code_dn;
          inband_q <= '0;
        end
        LVL_LOW: begin
          code_o   <= code_up;
          inband_q <= '0;
        end
        default: begin
          if (inband_q == LOCK_CNT) lock_o <= 1'b1;
          else                      inband_q <= inband_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/agc_rssi.sv
module agc_rssi #(
  parameter int CODE_W   = 7,
  parameter int PAD_COMP = 30
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              pad_i,
  output logic [CODE_W:0]   rssi_o
);
  localparam int EW = CODE_W + 1;
  localparam logic [EW-1:0] MAX_E = EW'((1 << CODE_W) - 1);
  localparam logic [EW-1:0] PAD_E = EW'(PAD_COMP);

  // gain removed from the chain; the pad term offsets its IF boost
  assign rssi_o = (MAX_E - {1'b0, code_i}) + (pad_i ? PAD_E : '0);
endmodule

// File: rtl/rx_agc_ctrl.sv
module rx_agc_ctrl #(
  parameter int SMP_W     = 6,
  parameter int CODE_W    = 7,
  parameter int WIN       = 16,
  parameter int STEP_DN   = 2,
  parameter int STEP_UP   = 1,
  parameter int PAD_COMP  = 30,
  parameter int LOCK_WINS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pkt_start_i,
  input  logic                    pkt_end_i,
  input  logic                    smp_vld_i,
  input  logic signed [SMP_W-1:0] smp_i_i,
  input  logic signed [SMP_W-1:0] smp_q_i,
  input  logic [SMP_W-1:0]        thr_hi_i,
  input  logic [SMP_W-1:0]        thr_lo_i,
  input  logic                    if_sat_i,
  output logic [CODE_W-1:0]       if_code_o,
  output logic                    rf_pad_o,
  output logic                    lock_o,
  output logic [CODE_W:0]         rssi_o
);
  logic             restart;
  logic             win_vld;
  logic [SMP_W-1:0] win_peak;

  agc_peak_meter #(.SMP_W(SMP_W), .WIN(WIN)) i_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (restart),
    .vld_i      (smp_vld_i),
    .i_i        (smp_i_i),
    .q_i        (smp_q_i),
    .win_vld_o  (win_vld),
    .win_peak_o (win_peak)
  );

  agc_gain_loop #(
    .SMP_W(SMP_W), .CODE_W(CODE_W), .STEP_DN(STEP_DN), .STEP_UP(STEP_UP),
    .PAD_COMP(PAD_COMP), .LOCK_WINS(LOCK_WINS)
  ) i_loop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pkt_start_i (pkt_start_i),
    .pkt_end_i   (pkt_end_i),
    .win_vld_i   (win_vld),
    .win_peak_i  (win_peak),
    .thr_hi_i    (thr_hi_i),
    .thr_lo_i    (thr_lo_i),
    .pad_req_i   (if_sat_i),
    .code_o      (if_code_o),
    .pad_o       (rf_pad_o),
    .lock_o      (lock_o),
    .restart_o   (restart)
  );

  agc_rssi #(.CODE_W(CODE_W), .PAD_COMP(PAD_COMP)) i_rssi (
    .code_i (if_code_o),
    .pad_i  (rf_pad_o),
    .rssi_o (rssi_o)
  );
endmodule

// File: rtl/rx_agc_ctrl_chk.sv
module rx_agc_ctrl_chk #(
  parameter int CODE_W   = 7,
  parameter int STEP_DN  = 2,
  parameter int STEP_UP  = 1,
  parameter int PAD_COMP = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pkt_end_i,
  input logic [CODE_W-1:0] if_code_o,
  input logic              rf_pad_o,
  input logic              lock_o,
  input logic [CODE_W:0]   rssi_o
);
  localparam int CMAX = (1 << CODE_W) - 1;

  assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !pkt_end_i) |=> ($stable(if_code_o) && $stable(rf_pad_o)));

  assert_end_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_i |=> (int'(if_code_o) == CMAX && !rf_pad_o && !lock_o));

  assert_pad_boost_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rf_pad_o) |-> (int'(if_code_o) ==
      ((int'($past(if_code_o)) + PAD_COMP > CMAX) ? CMAX : int'($past(if_code_o)) + PAD_COMP)));

  assert_pad_rssi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rf_pad_o) && (int'($past(if_code_o)) + PAD_COMP <= CMAX)) |-> $stable(rssi_o));

  // loop moves are one up-step or one down-step (saturating at 0)
  assert_loop_step_R3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(rf_pad_o) && !$past(pkt_end_i) && !$stable(if_code_o)) |->
      ((int'(if_code_o) == int'($past(if_code_o)) + STEP_UP) ||
       (int'(if_code_o) + STEP_DN == int'($past(if_code_o))) ||
       (if_code_o == '0 && int'($past(if_code_o)) < STEP_DN)));

  assert_pad_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_pad_o && !pkt_end_i) |=> rf_pad_o);
endmodule

bind rx_agc_ctrl rx_agc_ctrl_chk #(
  .CODE_W(CODE_W), .STEP_DN(STEP_DN), .STEP_UP(STEP_UP), .PAD_COMP(PAD_COMP)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pkt_end_i (pkt_end_i),
  .if_code_o (if_code_o),
  .rf_pad_o  (rf_pad_o),
  .lock_o    (lock_o),
  .rssi_o    (rssi_o)
);

// File: tb/test_rx_agc_ctrl.sv
module test_rx_agc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {i peak, q peak, expected code, expected lock}; thr_hi 28, thr_lo 20
  localparam int VEC [NV][4] = '{
    '{ 31,   2, 125, 0},   // R3 above
    '{  5, -32, 123, 0},   // R2 -32 is magnitude 32
    '{ 10,  -9, 124, 0},   // R4 below
    '{ -29,  4, 122, 0},   // R3
    '{ 24,   3, 122, 0},   // R5 in band, count 1
    '{ 15,   2, 123, 0},   // R5 out of band resets count
    '{ -28,  3, 123, 0},   // R5 upper edge in band
    '{  4,  20, 123, 1}    // R5 lower edge in band, lock
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pkt_start = 1'b0, pkt_end = 1'b0, vld = 1'b0, sat = 1'b0;
  logic signed [5:0] si = '0, sq = '0;
  logic [5:0] thr_hi = 6'd28, thr_lo = 6'd20;
  logic [6:0] code;
  logic pad, lock;
  logic [7:0] rssi;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_agc_ctrl i_rx_agc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pkt_start_i(pkt_start), .pkt_end_i(pkt_end),
    .smp_vld_i(vld), .smp_i_i(si), .smp_q_i(sq), .thr_hi_i(thr_hi), .thr_lo_i(thr_lo),
    .if_sat_i(sat), .if_code_o(code), .rf_pad_o(pad), .lock_o(lock), .rssi_o(rssi)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(int cnt, int ipk, int qpk);
    for (int j = 0; j < cnt; j++) begin
      @(negedge clk);
      vld = 1'b1;
      si  = (j == 5)  ? 6'(ipk) : 6'sd1;
      sq  = (j == 11) ? 6'(qpk) : -6'sd1;
    end
    @(negedge clk);
    vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) pkt_start = 1'b1;
    else if (which == 1) pkt_end = 1'b1;
    else sat = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0; pkt_end = 1'b0; sat = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code", int'(code), 127);
    chk("R1 pad", int'(pad), 0);
    chk("R1 lock", int'(lock), 0);
    chk("R1 rssi", int'(rssi), 0);

    send(16, 31, 31);
    chk("R9 idle samples ignored", int'(code), 127);

    pulse(0);
    for (int v = 0; v < NV; v++) begin
      send(16, VEC[v][0], VEC[v][1]);
      chk($sformatf("R3/R4/R5 vec%0d code", v), int'(code), VEC[v][2]);
      chk($sformatf("R5 vec%0d lock", v), int'(lock), VEC[v][3]);
    end
    chk("R8 rssi unpadded", int'(rssi), 127 - 123);

    send(16, 31, 31);
    chk("R6 locked code hold", int'(code), 123);
    pulse(2);
    chk("R6 locked pad hold", int'(pad), 0);

    pulse(1);
    chk("R9 end code", int'(code), 127);
    chk("R9 end lock", int'(lock), 0);
    send(16, 31, 31);
    chk("R9 post-end samples", int'(code), 127);
    pulse(2);
    chk("R9 post-end sat", int'(pad), 0);

    pulse(0);
    send(16, 5, 6);
    chk("R4 saturate 127", int'(code), 127);
    for (int k = 0; k < 64; k++) send(16, 31, 0);
    chk("R3 saturate 0", int'(code), 0);
    chk("R8 rssi at 0", int'(rssi), 127);
    pulse(2);
    chk("R7 pad on", int'(pad), 1);
    chk("R7 code boost", int'(code), 30);
    chk("R8 rssi unchanged on pad", int'(rssi), 127);
    send(16, 3, 3);
    chk("R4 up after pad", int'(code), 31);
    chk("R8 rssi padded", int'(rssi), 127 - 31 + 30);

    // R10: partial window of loud samples discarded by a new packet start
    send(10, 31, 31);
    pulse(0);
    send(16, 24, 0);
    chk("R10 partial discarded", int'(code), 31);
    chk("R10 count restarted", int'(lock), 0);
    send(16, 0, 22);
    chk("R10 lock after two", int'(lock), 1);

    pulse(1);
    pulse(0);
    pulse(2);
    chk("R7 pad at 127 saturates", int'(code), 127);
    chk("R8 rssi after saturated pad", int'(rssi), 30);

    finish_run();
  end
endmodule